// File: doc/BRIEF.md
# Addressed Serial Configuration Port for a Two-Channel Voice Processor

This block is the write-only configuration front end of a two-channel voice compression engine. A host drives a three-wire serial bus (active-low select, clock, data) that several such devices share. Every transaction opens with a command byte carrying a 6-bit device address and a channel selector. Only the device whose strapped address equals that field accepts the bytes that follow. The accepted bytes go into one of two register banks, X or Y: a control byte, and optionally an input time-slot byte and an output time-slot byte.

The serial pins are asynchronous to the block clock. They are synchronized and oversampled, so the serial clock must run well below the block clock. While a matched transaction is in progress, a busy flag asks both channels to float their data outputs. The algorithm-reset control bit clears itself after a fixed number of clock cycles. A strap-driven hardware mode turns the port off and derives each channel's configuration directly from the address straps and the two spare serial pins.

Top module: `cfgp_top`

## Requirements
- R1: Serial data is taken least-significant bit first, one bit per rising edge of `spi_sclk`. Only edges seen while `spi_csn` is low count, and every assertion of `spi_csn` starts a fresh byte and a fresh transaction.
- R2: The first byte of a transaction is the command. Bits 5..0 must equal `strap_addr`, and bit 7 must be 0; otherwise the transaction is not accepted. Bit 6 selects the bank: 1 selects X, 0 selects Y.
- R3: In an accepted transaction, the second byte is the control register, the third byte is the input slot register and the fourth byte is the output slot register, all in the selected bank. Any fifth or later byte has no effect. Control bit layout, bit 7 down to bit 0: rate select 0, rate select 1, idle, algorithm reset, bypass, law (1 = mu-law), rate select 2, compress (1 = compress).
- R4: A transaction whose command is not accepted changes no register in either bank.
- R5: Each register is written when its own byte completes. If `spi_csn` rises partway through a byte, that partial byte is discarded and registers written earlier in the transaction keep their new values.
- R6: A slot register keeps only bits 5..0 of its byte, and its bits 7..6 are dropped.
- R7: A synchronous reset sets both control registers to 0x20 (only the idle bit set) and both slot pairs to 0, and clears `cfg_busy`.
- R8: When a control write sets bit 4 (algorithm reset), the bit clears by itself ALRST_CYCLES clock cycles later. The other control bits are left unchanged.
- R9: `cfg_busy` is high from the accepted command byte until `spi_csn` is seen high. `out_hiz` bit 0 (X) and bit 1 (Y) each follow, one cycle later, `cfg_busy` OR that bank's idle bit.
- R10: When `hw_mode` is high, the port ignores serial traffic, `cfg_busy` stays low and all slot registers read 0. The control bytes are formed from pins, with every other control bit 0:
  - X takes compress from `strap_addr[0]`, law from `strap_addr[2]` and idle from `spi_csn`.
  - Y takes compress from `strap_addr[3]`, law from `strap_addr[5]` and idle from `spi_sdi`.
  - When `strap_addr[1]` and `strap_addr[4]` are both high, rate select 0 and 2 are 1 and rate select 1 is 0. Otherwise all rate selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_mode | input | 1 | High selects pin-strapped configuration |
| strap_addr | input | 6 | Device address straps; configuration pins in hardware mode |
| spi_sclk | input | 1 | Serial clock (asynchronous) |
| spi_sdi | input | 1 | Serial data; Y idle pin in hardware mode |
| spi_csn | input | 1 | Active-low select; X idle pin in hardware mode |
| ctrl_x | output | 8 | Bank X control register |
| ctrl_y | output | 8 | Bank Y control register |
| islot_x | output | 6 | Bank X input slot |
| oslot_x | output | 6 | Bank X output slot |
| islot_y | output | 6 | Bank Y input slot |
| oslot_y | output | 6 | Bank Y output slot |
| cfg_busy | output | 1 | Accepted update in progress |
| out_hiz | output | 2 | Output float request, bit 0 X, bit 1 Y |

## Verification
The bench targets the cases a serial decoder most often gets wrong.
- A design that shifts most-significant bit first would load bit-reversed control values.
- A design that counts clock edges while select is high would misframe the next command.
- A design that commits a partly shifted byte when select rises early would corrupt the slot register.
- A design that keeps reserved slot bits, or lets a fifth byte wrap onto the control register, would show wrong register values.
- A design that ignores reserved command bit 7, or compares the address badly, would let a foreign transaction write the registers.
- A design without the reset-bit countdown would leave bit 4 stuck.
- A miswired strap map in hardware mode would produce the wrong control bytes for both strap patterns.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W   = 8;
  localparam int SLOT_W   = 6;
  localparam int ADDR_W   = 6;
  localparam int NUM_BANK = 2;
  localparam int POS_W    = 3;

  // control bit positions (decoded by the channel datapath)
  localparam int CB_AS0   = 7;
  localparam int CB_AS1   = 6;
  localparam int CB_IDLE  = 5;
  localparam int CB_ALRST = 4;
  localparam int CB_BYP   = 3;
  localparam int CB_LAW   = 2;
  localparam int CB_AS2   = 1;
  localparam int CB_CPX   = 0;

  // command byte fields
  localparam int CMD_RSV  = 7;
  localparam int CMD_CHAN = 6;

  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'h20;

  typedef enum logic [POS_W-1:0] {
    POS_CMD   = 3'd0,
    POS_CTRL  = 3'd1,
    POS_ISLOT = 3'd2,
    POS_OSLOT = 3'd3,
    POS_EXTRA = 3'd4
  } byte_pos_e;

  localparam int BANK_X = 0;
  localparam int BANK_Y = 1;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[gi]}};
        else     chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cfgp_deser.sv
module cfgp_deser
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sdi,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output byte_pos_e         byte_pos
);
  localparam int BC_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shreg;
  logic [BC_W-1:0]   bitcnt;
  byte_pos_e         pos;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      shreg     <= '0;
      bitcnt    <= '0;
      pos       <= POS_CMD;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_pos  <= POS_CMD;
    end else begin
      byte_vld <= 1'b0;
      if (sclk_rise) begin
        shreg <= {sdi, shreg[BYTE_W-1:1]};
        if (bitcnt == BC_W'(BYTE_W - 1)) begin
          bitcnt    <= '0;
          byte_vld  <= 1'b1;
          byte_data <= {sdi, shreg[BYTE_W-1:1]};
          byte_pos  <= pos;
          if (pos != POS_EXTRA) pos <= byte_pos_e'(pos + 1'b1);
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !byte_vld);
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int ALRST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_mode,
  input  logic [BYTE_W-1:0] hw_ctrl,
  input  logic              wr_ctrl,
  input  logic              wr_islot,
  input  logic              wr_oslot,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl,
  output logic [SLOT_W-1:0] islot,
  output logic [SLOT_W-1:0] oslot
);
  localparam int CW = $clog2(ALRST_CYCLES + 1);

  logic [CW-1:0] alrst_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= CTRL_RESET;
      islot     <= '0;
      oslot     <= '0;
      alrst_cnt <= '0;
    end else if (hw_mode) begin
      ctrl      <= hw_ctrl;
      islot     <= '0;
      oslot     <= '0;
      alrst_cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl      <= wr_data;
        alrst_cnt <= wr_data[CB_ALRST] ? CW'(ALRST_CYCLES) : '0;
      end else if (alrst_cnt != '0) begin
        alrst_cnt <= alrst_cnt - 1'b1;
        if (alrst_cnt == CW'(1)) ctrl[CB_ALRST] <= 1'b0;
      end
      if (wr_islot) islot <= wr_data[SLOT_W-1:0];
      if (wr_oslot) oslot <= wr_data[SLOT_W-1:0];
    end
  end

  // R8
  alrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!hw_mode && !wr_ctrl && alrst_cnt == CW'(1)) |=> !ctrl[CB_ALRST]);

  // R8
  alrst_timer_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[CB_ALRST] |-> alrst_cnt != '0);

  // R10
  hw_slot_chk: assert property (@(posedge clk) disable iff (rst)
    hw_mode |=> (islot == '0 && oslot == '0));
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
  import cfgp_pkg::*;
#(
  parameter int ALRST_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  input  logic              spi_csn,
  output logic [BYTE_W-1:0] ctrl_x,
  output logic [BYTE_W-1:0] ctrl_y,
  output logic [SLOT_W-1:0] islot_x,
  output logic [SLOT_W-1:0] oslot_x,
  output logic [SLOT_W-1:0] islot_y,
  output logic [SLOT_W-1:0] oslot_y,
  output logic              cfg_busy,
  output logic [1:0]        out_hiz
);
  logic s_sclk, s_sdi, s_csn, sclk_prev;
  logic sclk_rise, cs_act;

  cfgp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_csn, spi_sdi, spi_sclk}),
    .q   ({s_csn, s_sdi, s_sclk})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= s_sclk;
  end

  assign sclk_rise = s_sclk & ~sclk_prev;
  assign cs_act    = ~s_csn & ~hw_mode;

  logic              byte_vld;
  logic [BYTE_W-1:0] byte_data;
  byte_pos_e         byte_pos;

  cfgp_deser u_deser (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sdi       (s_sdi),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_pos  (byte_pos)
  );

  // command decode: busy doubles as the accepted flag
  logic bank_sel;  // 0 = X, 1 = Y
  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      cfg_busy <= 1'b0;
      bank_sel <= 1'b0;
    end else if (byte_vld && byte_pos == POS_CMD) begin
      cfg_busy <= (byte_data[ADDR_W-1:0] == strap_addr) && !byte_data[CMD_RSV];
      bank_sel <= ~byte_data[CMD_CHAN];
    end
  end

  // strap-derived control bytes
  logic              rate16;
  logic [BYTE_W-1:0] hw_ctrl [NUM_BANK];
  always_comb begin
    rate16     = strap_addr[1] & strap_addr[4];
    hw_ctrl[BANK_X]           = '0;
    hw_ctrl[BANK_X][CB_AS0]   = rate16;
    hw_ctrl[BANK_X][CB_AS2]   = rate16;
    hw_ctrl[BANK_X][CB_IDLE]  = s_csn;
    hw_ctrl[BANK_X][CB_LAW]   = strap_addr[2];
    hw_ctrl[BANK_X][CB_CPX]   = strap_addr[0];
    hw_ctrl[BANK_Y]           = '0;
    hw_ctrl[BANK_Y][CB_AS0]   = rate16;
    hw_ctrl[BANK_Y][CB_AS2]   = rate16;
    hw_ctrl[BANK_Y][CB_IDLE]  = s_sdi;
    hw_ctrl[BANK_Y][CB_LAW]   = strap_addr[5];
    hw_ctrl[BANK_Y][CB_CPX]   = strap_addr[3];
  end

  logic [BYTE_W-1:0] b_ctrl  [NUM_BANK];
  logic [SLOT_W-1:0] b_islot [NUM_BANK];
  logic [SLOT_W-1:0] b_oslot [NUM_BANK];

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANK; gb++) begin : g_bank
      logic hit;
      assign hit = byte_vld && cfg_busy && (bank_sel == gb[0]);
      cfgp_bank #(.ALRST_CYCLES(ALRST_CYCLES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .hw_mode  (hw_mode),
        .hw_ctrl  (hw_ctrl[gb]),
        .wr_ctrl  (hit && byte_pos == POS_CTRL),
        .wr_islot (hit && byte_pos == POS_ISLOT),
        .wr_oslot (hit && byte_pos == POS_OSLOT),
        .wr_data  (byte_data),
        .ctrl     (b_ctrl[gb]),
        .islot    (b_islot[gb]),
        .oslot    (b_oslot[gb])
      );
    end
  endgenerate

  assign ctrl_x  = b_ctrl[BANK_X];
  assign ctrl_y  = b_ctrl[BANK_Y];
  assign islot_x = b_islot[BANK_X];
  assign oslot_x = b_oslot[BANK_X];
  assign islot_y = b_islot[BANK_Y];
  assign oslot_y = b_oslot[BANK_Y];

  always_ff @(posedge clk) begin
    if (rst) out_hiz <= 2'b11;
    else     out_hiz <= {cfg_busy | ctrl_y[CB_IDLE], cfg_busy | ctrl_x[CB_IDLE]};
  end

  // R9
  busy_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_busy |=> out_hiz == 2'b11);

  // R10
  hw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hw_mode |=> !cfg_busy);

  // R4
  write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && !cfg_busy) |=> ($stable(islot_x) && $stable(oslot_x)
                                 && $stable(islot_y) && $stable(oslot_y)));

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    s_csn |=> !cfg_busy);
endmodule

// File: tb/tb_cfgp_top.sv
module tb_cfgp_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst, hw_mode, spi_sclk, spi_sdi, spi_csn;
  logic [5:0] strap_addr;
  logic [7:0] ctrl_x, ctrl_y;
  logic [5:0] islot_x, oslot_x, islot_y, oslot_y;
  logic cfg_busy;
  logic [1:0] out_hiz;

  always #2.5 clk = ~clk;

  cfgp_top #(.ALRST_CYCLES(16)) dut (
    .clk(clk), .rst(rst), .hw_mode(hw_mode), .strap_addr(strap_addr),
    .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .spi_csn(spi_csn),
    .ctrl_x(ctrl_x), .ctrl_y(ctrl_y), .islot_x(islot_x), .oslot_x(oslot_x),
    .islot_y(islot_y), .oslot_y(oslot_y), .cfg_busy(cfg_busy), .out_hiz(out_hiz)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // expected model, index 0 = X, 1 = Y
  logic [7:0] em_ctrl [2];
  logic [5:0] em_is [2];
  logic [5:0] em_os [2];

  logic [42:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver side: snapshot of expected outputs after a transaction has settled
  task automatic push_exp(input string tag);
    exp_q.push_back({em_ctrl[0], em_ctrl[1], em_is[0], em_os[0], em_is[1], em_os[1],
                     1'b0, em_ctrl[1][5], em_ctrl[0][5]});
    tag_q.push_back(tag);
  endtask

  // monitor side: compare against the design output at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [42:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {21'd0, ctrl_x, ctrl_y, islot_x, oslot_x, islot_y, oslot_y,
                  cfg_busy, out_hiz}, {21'd0, e});
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      spi_sdi = b[i];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hw_mode = 1'b0; spi_sclk = 1'b0; spi_sdi = 1'b0; spi_csn = 1'b1;
    strap_addr = 6'h2A;
    for (int i = 0; i < 2; i++) begin em_ctrl[i] = 8'h20; em_is[i] = 0; em_os[i] = 0; end
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    push_exp("R7 reset state");
    @(negedge clk);

    // R1: clock edges with select high must not disturb framing
    send_bits(8'hFF, 3);
    // 4-byte write to X
    cs_lo();
    send_bits(8'h6A, 8);
    check("R9 busy after accepted command", {63'd0, cfg_busy}, 64'd1);
    check("R9 outputs floated while busy", {62'd0, out_hiz}, 64'd3);
    send_bits(8'h05, 8); send_bits(8'h07, 8); send_bits(8'h21, 8);
    cs_hi();
    em_ctrl[0] = 8'h05; em_is[0] = 6'h07; em_os[0] = 6'h21;
    push_exp("R1 R3 R9 four-byte write to X");
    @(negedge clk);

    // 2-byte write to Y, slots stay
    cs_lo(); send_bits(8'h2A, 8); send_bits(8'h8C, 8); cs_hi();
    em_ctrl[1] = 8'h8C;
    push_exp("R3 two-byte write to Y");
    @(negedge clk);

    // address mismatch
    cs_lo(); send_bits(8'h6B, 8);
    check("R4 busy stays low on mismatch", {63'd0, cfg_busy}, 64'd0);
    send_bits(8'h00, 8); send_bits(8'h11, 8); send_bits(8'h12, 8); cs_hi();
    push_exp("R4 mismatched address ignored");
    @(negedge clk);

    // reserved command bit set
    cs_lo(); send_bits(8'hEA, 8); send_bits(8'h00, 8); send_bits(8'h13, 8); cs_hi();
    push_exp("R2 reserved command bit rejects");
    @(negedge clk);

    // abort inside third byte
    cs_lo(); send_bits(8'h6A, 8); send_bits(8'h45, 8); send_bits(8'h3F, 3); cs_hi();
    em_ctrl[0] = 8'h45;
    push_exp("R5 partial byte discarded");
    @(negedge clk);

    // reserved slot bits dropped
    cs_lo(); send_bits(8'h2A, 8); send_bits(8'h8C, 8); send_bits(8'hFF, 8);
    send_bits(8'hC5, 8); cs_hi();
    em_is[1] = 6'h3F; em_os[1] = 6'h05;
    push_exp("R6 slot upper bits dropped");
    @(negedge clk);

    // self-clearing algorithm reset
    cs_lo(); send_bits(8'h6A, 8); send_bits(8'h14, 8);
    check("R8 reset bit set after write", {56'd0, ctrl_x}, 64'h14);
    cs_hi();
    em_ctrl[0] = 8'h04;
    push_exp("R8 reset bit cleared itself");
    @(negedge clk);

    // fifth byte ignored
    cs_lo(); send_bits(8'h6A, 8); send_bits(8'h01, 8); send_bits(8'h02, 8);
    send_bits(8'h03, 8); send_bits(8'h3F, 8); cs_hi();
    em_ctrl[0] = 8'h01; em_is[0] = 6'h02; em_os[0] = 6'h03;
    push_exp("R3 extra byte no effect");
    @(negedge clk);

    // hardware mode, pattern 1
    hw_mode = 1'b1; strap_addr = 6'b010010; spi_sdi = 1'b1; spi_csn = 1'b0;
    repeat (12) @(negedge clk);
    em_ctrl[0] = 8'h82; em_ctrl[1] = 8'hA2;
    for (int i = 0; i < 2; i++) begin em_is[i] = 0; em_os[i] = 0; end
    push_exp("R10 hardware pattern 16k");
    @(negedge clk);

    // hardware mode, pattern 2
    strap_addr = 6'b101101; spi_sdi = 1'b0; spi_csn = 1'b1;
    repeat (12) @(negedge clk);
    em_ctrl[0] = 8'h25; em_ctrl[1] = 8'h05;
    push_exp("R10 hardware pattern 32k");
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule